// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital timing core of a 10-bit successive-approximation converter with a one-wire serial result output. An active-low start request opens a conversion frame that always lasts 14 conversion clocks. In clocks 1 and 2 the analog front end calibrates and tracks. The input is held on the falling edge of clock 3. The following ten clocks resolve one bit each, MSB first. Each resolved bit is shifted out on a falling edge of the conversion clock.

The converter has no mode register. Its behaviour depends only on how the start request is driven. If the request is high when clock 14 falls, the block releases the output and idles (single shot). If the request is low at that edge, either because it stayed low (free run) or because it was dropped again during the frame (synchronized), the next frame begins on the very next rising edge. In that case the output stays driven low between frames.

The whole block runs on one system clock at twice the conversion rate. A phase toggle supplies rise and fall enables in place of the two conversion-clock edges. The comparator is an input, and the trial code drives the external DAC. A parallel result and a one-cycle done pulse are brought out so that the result can be checked.

Top module: `sar_serial_seq`

## Requirements
- R1: With start_n low at a conversion-clock rising edge while idle, that edge becomes clock 1 of a frame, and sdo_oe is asserted from that edge.
- R2: A frame is exactly 14 conversion clocks, that is 28 system clocks. When frames run back to back, successive done pulses are 28 system clocks apart.
- R3: hold_o is low while idle and in clocks 1 to 3 before the fall of clock 3. It goes high at the fall of clock 3 and returns low at the rise of clock 14.
- R4: trial_code equals the bits already decided, OR-ed with a single one at the bit under test. During clock 4, before the MSB decision, it is 10'b1000000000. cmp_in = 1 means the input is at or above the trial and keeps that bit.
- R5: The bit decided at the fall of clock 4+i (i = 0 for the MSB) appears on sdo_data from that edge until the next falling edge, so bits leave MSB first.
- R6: At the rise of clock 14, sdo_data returns low, so the LSB is present only in the low half of clock 13.
- R7: From clock 1 until the MSB is launched at the fall of clock 4, the output is driven low (sdo_oe = 1, sdo_data = 0).
- R8: If start_n is high at the fall of clock 14, sdo_oe drops at that edge, and no new frame starts while start_n stays high.
- R9: If start_n goes high during a frame and is low again at the fall of clock 14, the next frame starts on the following rising edge. A frame released to idle restarts on the first rising edge after start_n falls.
- R10: With start_n held low, frames follow one another with the output driven low (sdo_oe = 1, sdo_data = 0) between them.
- R11: The result is straight binary: all ones at full scale and all zeros at the bottom. result is loaded and done pulses for one system clock at the fall of clock 13.
- R12: cclk_o is the conversion clock at half the system rate. It is low in reset and rises on the first system edge after reset is released. In reset, sdo_oe, hold_o, done and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the conversion rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low start-convert request |
| cmp_in | input | 1 | Comparator decision, 1 when input is at or above trial_code |
| cclk_o | output | 1 | Conversion clock level derived from the phase toggle |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| trial_code | output | 10 | Trial code for the external DAC |
| sdo_data | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial output drive enable, 0 = high impedance |
| result | output | 10 | Parallel result of the last frame |
| done | output | 1 | One-cycle pulse when result is loaded |

## Verification
The bench builds the block with its defaults: 10 result bits and 2 calibration clocks, which gives the 14-clock frame. At this size every conversion-clock index of a frame can be named and checked on its own half-period. Full-scale, zero and alternating-bit inputs drive every trial-code path. Single-shot, synchronized and free-running sequences exercise each decision taken at the fall of clock 14.

// File: rtl/sar_seq_pkg.sv
// Shared types for the serial SAR sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;

    // Drive state of the serial output pin.
    typedef enum logic [1:0] {
        SDO_HIZ = 2'd0,
        SDO_LOW = 2'd1,
        SDO_BIT = 2'd2
    } sdo_mode_e;

    // Conversion clocks per frame: calibration, sample, one per bit, ready.
    function automatic int frame_clocks(input int cal_clks, input int res_bits);
        return cal_clks + res_bits + 2;
    endfunction

endpackage

// File: rtl/sar_phase_gen.sv
// Conversion-clock phase generator.
// Splits the system clock into alternating rise and fall enables. The
// conversion clock level is high between a rise enable and the next
// fall enable. Assumes: the system clock runs at twice the conversion rate.
module sar_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic rise_en,
    output logic fall_en,
    output logic cclk
);

    logic phase;

    // Toggle the phase every system clock; low out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    assign rise_en = ~phase;
    assign fall_en = phase;
    assign cclk    = phase;

endmodule

// File: rtl/sar_frame_ctrl.sv
// Frame controller.
// Numbers the conversion clocks of a frame (0 = idle), drives the
// track/hold control and emits the edge events the rest of the block uses.
// start_n is looked at on rising edges while idle and on the falling edge
// of the last clock of a frame. Assumes: rise_en and fall_en alternate.
module sar_frame_ctrl #(
    parameter  int CAL_CLKS   = 2,
    parameter  int RES_BITS   = 10,
    localparam int FRAME_CLKS = sar_seq_pkg::frame_clocks(CAL_CLKS, RES_BITS),
    localparam int CW         = $clog2(FRAME_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_en,
    input  logic          fall_en,
    input  logic          start_n,
    output logic [CW-1:0] clk_no,
    output logic          hold,
    output logic          start_ev,
    output logic          samp_ev,
    output logic          bit_ev,
    output logic          ready_ev,
    output logic          stop_ev
);

    localparam logic [CW-1:0] C_SAMPLE = CW'(CAL_CLKS + 1);
    localparam logic [CW-1:0] C_FIRST  = CW'(CAL_CLKS + 2);
    localparam logic [CW-1:0] C_LAST   = CW'(CAL_CLKS + 1 + RES_BITS);
    localparam logic [CW-1:0] C_FRAME  = CW'(FRAME_CLKS);

    logic armed;

    // Edge events derived from the clock number.
    always_comb begin
        start_ev = rise_en && (((clk_no == '0) && !start_n) || armed);
        samp_ev  = fall_en && (clk_no == C_SAMPLE);
        bit_ev   = fall_en && (clk_no >= C_FIRST) && (clk_no <= C_LAST);
        ready_ev = rise_en && (clk_no == C_LAST);
        stop_ev  = fall_en && (clk_no == C_FRAME) && start_n;
    end

    // Advance the clock number and decide at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_no <= '0;
            armed  <= 1'b0;
        end else if (start_ev) begin
            clk_no <= CW'(1);
            armed  <= 1'b0;
        end else if (rise_en && (clk_no != '0) && (clk_no < C_FRAME)) begin
            clk_no <= clk_no + CW'(1);
        end else if (fall_en && (clk_no == C_FRAME)) begin
            if (start_n) clk_no <= '0;
            else         armed  <= 1'b1;
        end
    end

    // Hold from the sample edge until the ready edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold <= 1'b0;
        else if (samp_ev)  hold <= 1'b1;
        else if (ready_ev) hold <= 1'b0;
    end

    // R3: hold only inside the sample-to-ready window.
    a_r3_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (clk_no >= C_SAMPLE) && (clk_no <= C_LAST));

    // R1: an idle rising edge with start low opens clock 1.
    a_r1_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && (clk_no == '0) && !start_n) |=> (clk_no == CW'(1)));

endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register.
// A one-hot mask marks the bit under test. Decided bits accumulate in
// the code register, and the trial code is their union. The result loads
// when the mask reaches the LSB. Assumes: samp_ev precedes RES_BITS bit_ev.
module sar_approx_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_ev,
    input  logic                bit_ev,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result,
    output logic                done
);

    logic [RES_BITS-1:0] mask;
    logic [RES_BITS-1:0] code;
    logic                last_bit;

    assign last_bit   = bit_ev && mask[0];
    assign trial_code = code | mask;

    // Step the mask and keep or drop the bit under test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            code <= '0;
        end else if (samp_ev) begin
            mask <= {1'b1, {(RES_BITS-1){1'b0}}};
            code <= '0;
        end else if (bit_ev) begin
            if (cmp_in) code <= code | mask;
            mask <= mask >> 1;
        end
    end

    // Load the finished code and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last_bit;
            if (last_bit) result <= code | (cmp_in ? mask : '0);
        end
    end

    // R11: done is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: after the last decision the trial code has converged to the result.
    a_r11_result_match: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trial_code == result));

endmodule

// File: rtl/sar_sdo_drv.sv
// Serial output driver.
// Holds the pin state (high impedance, driven low, or driving a result
// bit) and updates it from the frame events. Assumes: at most one event
// per cycle, except start_ev, which may coincide with nothing else.
module sar_sdo_drv
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ev,
    input  logic bit_ev,
    input  logic bit_val,
    input  logic ready_ev,
    input  logic stop_ev,
    output logic sdo_oe,
    output logic sdo_data
);

    sdo_mode_e mode;
    logic      bit_q;

    // Update the pin state on frame events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= SDO_HIZ;
            bit_q <= 1'b0;
        end else if (stop_ev) begin
            mode  <= SDO_HIZ;
        end else if (start_ev || ready_ev) begin
            mode  <= SDO_LOW;
        end else if (bit_ev) begin
            mode  <= SDO_BIT;
            bit_q <= bit_val;
        end
    end

    assign sdo_oe   = (mode != SDO_HIZ);
    assign sdo_data = (mode == SDO_BIT) && bit_q;

endmodule

// File: rtl/sar_serial_seq.sv
// Serial SAR converter control sequencer (top).
// Ties the phase generator, frame controller, approximation register and
// serial driver together. Assumes: cmp_in is valid at every falling
// conversion edge for the trial_code presented since the previous one.
module sar_serial_seq #(
    parameter  int CAL_CLKS   = 2,
    parameter  int RES_BITS   = 10,
    localparam int FRAME_CLKS = sar_seq_pkg::frame_clocks(CAL_CLKS, RES_BITS),
    localparam int CW         = $clog2(FRAME_CLKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_n,
    input  logic                cmp_in,
    output logic                cclk_o,
    output logic                hold_o,
    output logic [RES_BITS-1:0] trial_code,
    output logic                sdo_data,
    output logic                sdo_oe,
    output logic [RES_BITS-1:0] result,
    output logic                done
);

    localparam logic [CW-1:0] C_FIRST = CW'(CAL_CLKS + 2);
    localparam logic [CW-1:0] C_LAST  = CW'(CAL_CLKS + 1 + RES_BITS);
    localparam logic [CW-1:0] C_FRAME = CW'(FRAME_CLKS);

    logic          rise_en, fall_en;
    logic [CW-1:0] clk_no;
    logic          start_ev, samp_ev, bit_ev, ready_ev, stop_ev;

    sar_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .cclk    (cclk_o)
    );

    sar_frame_ctrl #(.CAL_CLKS(CAL_CLKS), .RES_BITS(RES_BITS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .start_n  (start_n),
        .clk_no   (clk_no),
        .hold     (hold_o),
        .start_ev (start_ev),
        .samp_ev  (samp_ev),
        .bit_ev   (bit_ev),
        .ready_ev (ready_ev),
        .stop_ev  (stop_ev)
    );

    sar_approx_reg #(.RES_BITS(RES_BITS)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_ev    (samp_ev),
        .bit_ev     (bit_ev),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .result     (result),
        .done       (done)
    );

    sar_sdo_drv u_sdo (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ev (start_ev),
        .bit_ev   (bit_ev),
        .bit_val  (cmp_in),
        .ready_ev (ready_ev),
        .stop_ev  (stop_ev),
        .sdo_oe   (sdo_oe),
        .sdo_data (sdo_data)
    );

    // R7: output driven low from clock 1 until the MSB launches.
    a_r7_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_no != '0) && (clk_no < C_FIRST)) |-> (sdo_oe && !sdo_data));

    // R8: no drive while idle.
    a_r8_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_no == '0) |-> !sdo_oe);

    // R10: during the final clock the pin is driven low.
    a_r10_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_no == C_FRAME) |-> (sdo_oe && !sdo_data));

    // R11: the result completes in the last bit clock.
    a_r11_done_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_no == C_LAST));

endmodule

// File: tb/test_sar_serial_seq.sv
// Directed bench for the serial SAR sequencer. An ideal comparator
// compares the bench value vin against trial_code.
module test_sar_serial_seq;

    localparam int  N      = 10;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n, start_n;
    logic [N-1:0] vin;
    logic         cmp_in, cclk_o, hold_o, sdo_data, sdo_oe, done;
    logic [N-1:0] trial_code, result;

    int  n_chk = 0, n_fail = 0, sys_cyc = 0, done_cyc = 0;
    bit  hi;
    bit  finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) sys_cyc <= sys_cyc + 1;
    assign cmp_in = (vin >= trial_code);

    sar_serial_seq #(.CAL_CLKS(2), .RES_BITS(N)) i_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp_in(cmp_in),
        .cclk_o(cclk_o), .hold_o(hold_o), .trial_code(trial_code),
        .sdo_data(sdo_data), .sdo_oe(sdo_oe), .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One half conversion period; hi is set in a high half.
    task automatic adv();
        @(negedge clk);
        hi = cclk_o;
    endtask

    // Runs one frame up to the high half of clock 14, checking each half.
    task automatic do_frame(input logic [N-1:0] v, input int raise_at, input int lower_at);
        vin = v;
        do adv(); while (!hi);
        for (int c = 1; c <= 14; c++) begin
            if (c == raise_at) start_n = 1'b1;
            if (c == lower_at) start_n = 1'b0;
            if (c == 1) chk(sdo_oe && !sdo_data, "R1", {sdo_oe, sdo_data}, 2);
            if (c <= 3) chk(!hold_o, "R3", hold_o, 0);
            if (c == 4) begin
                chk(!sdo_data, "R7", sdo_data, 0);
                chk(trial_code == 10'h200, "R4", trial_code, 10'h200);
            end
            if (c == 5) chk(trial_code == ((v & 10'h200) | 10'h100), "R4",
                            trial_code, (v & 10'h200) | 10'h100);
            if (c >= 5 && c <= 13)
                chk(sdo_data == v[N-1-(c-5)], "R5", sdo_data, v[N-1-(c-5)]);
            if (c == 14) begin
                chk(sdo_oe && !sdo_data, "R6", {sdo_oe, sdo_data}, 2);
                chk(!hold_o, "R3", hold_o, 0);
            end
            if (c < 14) begin
                adv();
                if (c <= 3) chk(sdo_oe && !sdo_data, "R7", {sdo_oe, sdo_data}, 2);
                if (c == 3) chk(hold_o, "R3", hold_o, 1);
                if (c >= 4) begin
                    chk(sdo_data == v[N-1-(c-4)], "R5", sdo_data, v[N-1-(c-4)]);
                    chk(hold_o, "R3", hold_o, 1);
                end
                if (c == 12) chk(!done, "R11", done, 0);
                if (c == 13) begin
                    chk(done && result == v, "R11", result, v);
                    done_cyc = sys_cyc;
                end
                adv();
            end
        end
    endtask

    task automatic t_reset();
        chk(!cclk_o && !sdo_oe && !hold_o && !done && result == '0, "R12",
            {cclk_o, sdo_oe, hold_o, done}, 0);
    endtask

    task automatic t_idle();
        bit prev;
        adv();
        chk(cclk_o, "R12", cclk_o, 1);
        prev = cclk_o;
        for (int i = 0; i < 8; i++) begin
            adv();
            chk(cclk_o != prev, "R12", cclk_o, !prev);
            chk(!sdo_oe && !hold_o && !done, "R8", {sdo_oe, hold_o, done}, 0);
            prev = cclk_o;
        end
    endtask

    task automatic t_single(input logic [N-1:0] v);
        start_n = 1'b0;
        do_frame(v, 2, 0);
        adv();
        chk(!sdo_oe, "R8", sdo_oe, 0);
        for (int i = 0; i < 6; i++) begin
            adv();
            chk(!sdo_oe && !hold_o && !done, "R8", {sdo_oe, hold_o, done}, 0);
        end
    endtask

    task automatic t_sync();
        int d0;
        start_n = 1'b0;
        do_frame(10'h2AA, 2, 10);
        d0 = done_cyc;
        adv();
        chk(sdo_oe && !sdo_data, "R9", {sdo_oe, sdo_data}, 2);
        do_frame(10'h155, 2, 0);
        chk(done_cyc - d0 == 28, "R9", done_cyc - d0, 28);
        adv();
        chk(!sdo_oe, "R9", sdo_oe, 0);
        start_n = 1'b0;
        d0 = done_cyc;
        do_frame(10'h200, 2, 0);
        chk(done_cyc - d0 == 28, "R9", done_cyc - d0, 28);
        adv();
        chk(!sdo_oe, "R8", sdo_oe, 0);
    endtask

    task automatic t_free();
        int d0;
        start_n = 1'b0;
        do_frame(10'h1FF, 0, 0);
        d0 = done_cyc;
        adv();
        chk(sdo_oe && !sdo_data, "R10", {sdo_oe, sdo_data}, 2);
        do_frame(10'h3FF, 0, 0);
        chk(done_cyc - d0 == 28, "R2", done_cyc - d0, 28);
        d0 = done_cyc;
        adv();
        chk(sdo_oe && !sdo_data, "R10", {sdo_oe, sdo_data}, 2);
        do_frame(10'h000, 0, 0);
        chk(done_cyc - d0 == 28, "R2", done_cyc - d0, 28);
        start_n = 1'b1;
        adv();
        chk(!sdo_oe, "R8", sdo_oe, 0);
    endtask

    initial begin
        rst_n = 1'b0; start_n = 1'b1; vin = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_single(10'h3FF);
        t_single(10'h000);
        t_single(10'h2D3);
        t_sync();
        t_free();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule